// File: doc/BRIEF.md
# Two-Bit Burst Address Sequencer

This block produces the word address for a four-beat burst in a synchronous cache memory. A burst starts when one of two active-low address strobes is accepted on a rising clock edge: one strobe comes from the processor and one from the cache controller. The full incoming address is captured on that edge. The two least significant bits of that address become the first beat of a two-bit counter that wraps around.

On later edges with no strobe present, an active-low advance input either steps the burst to its next beat or holds it on the current one. A mode input picks the beat order for each step:

- Interleaved order: the start bits XOR the beat number.
- Linear order: the start bits plus the beat number, modulo four.

The upper address bits never change inside a burst. Three chip enables qualify the strobes: two are active low and one is active high.

The block registers both of its outputs: the full word address and the beat index.

Top module: `burst_seq_top`

## Requirements
- R1: A synchronous reset (rst high at a rising edge) sets wordAddr and beatIdx to zero at that edge.
- R2: When procStrobeN is low and all enables are active at a rising edge, wordAddr takes addrIn and beatIdx becomes 0 at that edge. The enables are active when ce1N is low, ce2 is high and ce3N is low.
- R3: When ctrlStrobeN is low, procStrobeN is high and all enables are active at a rising edge, wordAddr takes addrIn and beatIdx becomes 0.
- R4: When both strobes are low with all enables active, exactly one load of addrIn takes place: wordAddr equals addrIn and beatIdx is 0.
- R5: Two cases leave wordAddr and beatIdx unchanged, whatever advN is:
  - an accepted strobe arrives while any enable is inactive;
  - procStrobeN is low while ce1N is low and ce2 or ce3N is inactive.
  A processor strobe with ce1N high is ignored entirely. With ctrlStrobeN high, advN then acts as if no strobe were present.
- R6: With no accepted strobe, advN low and interleave = 1, the low two bits of wordAddr become start XOR beat, and beatIdx increments by one.
- R7: With no accepted strobe, advN low and interleave = 0, the low two bits become (start + beat) mod 4, and beatIdx increments by one.
- R8: With no accepted strobe and advN high, wordAddr and beatIdx hold their values.
- R9: After the fourth beat, the next advance wraps beatIdx to 0 and the low bits back to the start bits, with no carry into the upper bits.
- R10: interleave is sampled at every advance. A change of mode in the middle of a burst applies the new order to the same start bits and the next beat number.
- R11: The upper address bits (above the two low bits) change only on a load or a reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| addrIn | input | ADDR_W | Address presented with a strobe |
| ce1N | input | 1 | Chip enable, active low; also gates the processor strobe |
| ce2 | input | 1 | Chip enable, active high |
| ce3N | input | 1 | Chip enable, active low |
| procStrobeN | input | 1 | Processor address strobe, active low, priority strobe |
| ctrlStrobeN | input | 1 | Controller address strobe, active low |
| advN | input | 1 | Advance, active low: low steps the burst, high holds it |
| interleave | input | 1 | Order select: 1 interleaved (XOR), 0 linear (wrapping add) |
| wordAddr | output | ADDR_W | Registered word address of the current beat |
| beatIdx | output | BEAT_BITS | Registered beat index within the burst |

## Verification
The bench builds the block with ADDR_W = 10 and BEAT_BITS = 2. The narrow address lets it use starts with every upper bit set, such as 0x3FF, where a carry out of the low bits would show up at once. All four start values are covered, and full four-beat wraps are run in both orders. A mid-burst order change, the strobe priority, and every enable combination that blocks a load are each checked at the ports.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;

  // Command from the control decode to the address datapath.
  typedef struct packed {
    logic load;  // capture a new start address
    logic step;  // advance to the next beat
  } seqCmd_t;

endpackage

// File: rtl/burst_seq_ctrl.sv
module burst_seq_ctrl
  import burst_seq_pkg::*;
(
  input  logic    ce1N,
  input  logic    ce2,
  input  logic    ce3N,
  input  logic    procStrobeN,
  input  logic    ctrlStrobeN,
  input  logic    advN,
  output seqCmd_t cmd
);

  logic procSeen;
  logic ctrlSeen;
  logic anyStrobe;
  logic allEn;

  // The processor strobe only counts when ce1N is low.
  // While it counts, the controller strobe is ignored.
  assign procSeen  = !procStrobeN && !ce1N;
  assign ctrlSeen  = !ctrlStrobeN && !procSeen;
  assign anyStrobe = procSeen || ctrlSeen;
  assign allEn     = !ce1N && ce2 && !ce3N;

  always_comb begin
    cmd      = '0;
    cmd.load = anyStrobe && allEn;
    cmd.step = !anyStrobe && !advN;
  end

endmodule

// File: rtl/burst_seq_dp.sv
module burst_seq_dp
  import burst_seq_pkg::*;
#(
  parameter int ADDR_W    = 17,
  parameter int BEAT_BITS = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  seqCmd_t              cmd,
  input  logic [ADDR_W-1:0]    addrIn,
  input  logic                 interleave,
  output logic [ADDR_W-1:0]    wordAddr,
  output logic [BEAT_BITS-1:0] beatIdx
);

  localparam int UP_W = ADDR_W - BEAT_BITS;
  localparam logic [BEAT_BITS-1:0] BEAT_LAST = {BEAT_BITS{1'b1}};
  localparam logic [BEAT_BITS-1:0] BEAT_ONE  = BEAT_BITS'(1);

  logic [UP_W-1:0]      upperQ;
  logic [BEAT_BITS-1:0] startQ;
  logic [BEAT_BITS-1:0] beatQ;
  logic [BEAT_BITS-1:0] lowQ;
  logic [BEAT_BITS-1:0] nextBeat;
  logic [BEAT_BITS-1:0] nextLow;

  assign nextBeat = beatQ + BEAT_ONE;
  assign nextLow  = interleave ? (startQ ^ nextBeat) : (startQ + nextBeat);

  always_ff @(posedge clk) begin
    if (rst) begin
      upperQ <= '0;
      startQ <= '0;
      beatQ  <= '0;
      lowQ   <= '0;
    end else if (cmd.load) begin
      upperQ <= addrIn[ADDR_W-1:BEAT_BITS];
      startQ <= addrIn[BEAT_BITS-1:0];
      beatQ  <= '0;
      lowQ   <= addrIn[BEAT_BITS-1:0];
    end else if (cmd.step) begin
      beatQ <= nextBeat;
      lowQ  <= nextLow;
    end
  end

  assign wordAddr = {upperQ, lowQ};
  assign beatIdx  = beatQ;

  // R2
  load_capture_chk: assert property (@(posedge clk) disable iff (rst)
    cmd.load |=> (wordAddr == $past(addrIn)) && (beatIdx == '0));

  // R8
  hold_stable_chk: assert property (@(posedge clk) disable iff (rst)
    (!cmd.load && !cmd.step) |=> $stable(wordAddr) && $stable(beatIdx));

  // R6
  step_count_chk: assert property (@(posedge clk) disable iff (rst)
    cmd.step |=> beatIdx == $past(beatIdx) + BEAT_ONE);

  // R9
  wrap_start_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd.step && beatQ == BEAT_LAST) |=> lowQ == startQ && beatIdx == '0);

  // R11
  upper_stable_chk: assert property (@(posedge clk) disable iff (rst)
    !cmd.load |=> $stable(wordAddr[ADDR_W-1:BEAT_BITS]));

endmodule

// File: rtl/burst_seq_top.sv
module burst_seq_top
  import burst_seq_pkg::*;
#(
  parameter int ADDR_W    = 17,
  parameter int BEAT_BITS = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [ADDR_W-1:0]    addrIn,
  input  logic                 ce1N,
  input  logic                 ce2,
  input  logic                 ce3N,
  input  logic                 procStrobeN,
  input  logic                 ctrlStrobeN,
  input  logic                 advN,
  input  logic                 interleave,
  output logic [ADDR_W-1:0]    wordAddr,
  output logic [BEAT_BITS-1:0] beatIdx
);

  seqCmd_t cmd;

  burst_seq_ctrl ctrl_i (
    .ce1N        (ce1N),
    .ce2         (ce2),
    .ce3N        (ce3N),
    .procStrobeN (procStrobeN),
    .ctrlStrobeN (ctrlStrobeN),
    .advN        (advN),
    .cmd         (cmd)
  );

  burst_seq_dp #(
    .ADDR_W    (ADDR_W),
    .BEAT_BITS (BEAT_BITS)
  ) dp_i (
    .clk        (clk),
    .rst        (rst),
    .cmd        (cmd),
    .addrIn     (addrIn),
    .interleave (interleave),
    .wordAddr   (wordAddr),
    .beatIdx    (beatIdx)
  );

  // R1
  reset_zero_chk: assert property (@(posedge clk)
    rst |=> (wordAddr == '0) && (beatIdx == '0));

endmodule

// File: tb/burst_seq_top_tb_top.sv
module burst_seq_top_tb_top;

  localparam int AW = 10;
  localparam int BB = 2;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [AW-1:0] addrIn = '0;
  logic          ce1N = 1'b1;
  logic          ce2 = 1'b0;
  logic          ce3N = 1'b1;
  logic          procStrobeN = 1'b1;
  logic          ctrlStrobeN = 1'b1;
  logic          advN = 1'b1;
  logic          interleave = 1'b1;
  logic [AW-1:0] wordAddr;
  logic [BB-1:0] beatIdx;

  always #2 clk = ~clk;

  burst_seq_top #(.ADDR_W(AW), .BEAT_BITS(BB)) dut_i (
    .clk(clk), .rst(rst), .addrIn(addrIn), .ce1N(ce1N), .ce2(ce2), .ce3N(ce3N),
    .procStrobeN(procStrobeN), .ctrlStrobeN(ctrlStrobeN), .advN(advN),
    .interleave(interleave), .wordAddr(wordAddr), .beatIdx(beatIdx)
  );

  typedef struct {
    logic [AW-1:0] addr;
    logic [BB-1:0] beat;
    string         req;
  } expItem_t;

  expItem_t expQ[$];
  int checks = 0;
  int errors = 0;
  bit done = 0;

  // Reference state, kept from the requirements
  logic [AW-3:0] mUp = '0;
  logic [1:0]    mStart = '0, mBeat = '0, mLow = '0;

  // Monitor: compare one item per cycle, away from the rising edge
  always @(negedge clk) begin
    if (expQ.size() > 0) begin
      expItem_t e;
      e = expQ.pop_front();
      checks++;
      if (wordAddr !== e.addr || beatIdx !== e.beat) begin
        errors++;
        $display("FAIL %s: addr=%h beat=%0d expected addr=%h beat=%0d",
                 e.req, wordAddr, beatIdx, e.addr, e.beat);
      end
    end
  end

  task automatic pushExp(input string req);
    expItem_t e;
    e.addr = {mUp, mLow};
    e.beat = mBeat;
    e.req  = req;
    expQ.push_back(e);
  endtask

  task automatic doReset(input string req);
    @(negedge clk);
    rst = 1'b1; procStrobeN = 1'b1; ctrlStrobeN = 1'b1; advN = 1'b0;
    @(posedge clk);
    mUp = '0; mStart = '0; mBeat = '0; mLow = '0;
    pushExp(req);
    @(negedge clk);
    rst = 1'b0; advN = 1'b1;
  endtask

  // Driver: apply one cycle of inputs, update the reference, push expected
  task automatic drive(input logic [AW-1:0] a, input logic c1, input logic c2,
                       input logic c3, input logic p, input logic c,
                       input logic adv, input logic md, input string req);
    logic procSeen, anyS, allEn;
    @(negedge clk);
    addrIn = a; ce1N = c1; ce2 = c2; ce3N = c3;
    procStrobeN = p; ctrlStrobeN = c; advN = adv; interleave = md;
    @(posedge clk);
    procSeen = !p && !c1;
    anyS     = procSeen || !c;
    allEn    = !c1 && c2 && !c3;
    if (anyS) begin
      if (allEn) begin
        mUp = a[AW-1:2]; mStart = a[1:0]; mBeat = 2'd0; mLow = a[1:0];
      end
    end else if (!adv) begin
      mBeat = mBeat + 2'd1;
      mLow  = md ? (mStart ^ mBeat) : (mStart + mBeat);
    end
    pushExp(req);
  endtask

  // Short forms
  task automatic advance(input logic md, input string req);
    drive('0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, md, req);
  endtask

  task automatic idle(input string req);
    drive('0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, req);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: run hung, got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    doReset("R1 reset clears outputs");

    // Processor strobe load, interleaved burst from start 01
    drive(10'h2D5, 0, 1, 0, 0, 1, 1, 1, "R2 processor load");
    advance(1, "R6 interleave beat 1");
    advance(1, "R6 interleave beat 2");
    advance(1, "R6 interleave beat 3");
    advance(1, "R9 interleave wrap to start");
    idle("R8 hold on advN high");
    idle("R8 hold second cycle");

    // Controller strobe load, linear burst from start 10
    drive(10'h13E, 0, 1, 0, 1, 0, 1, 0, "R3 controller load");
    advance(0, "R7 linear beat 1");
    advance(0, "R7 linear beat 2");
    advance(0, "R7 linear beat 3");
    advance(0, "R9 linear wrap to start");
    advance(0, "R11 upper bits unchanged after wrap");

    // Both strobes low: one load
    drive(10'h0A3, 0, 1, 0, 0, 0, 0, 1, "R4 both strobes one load");

    // Gating by chip enables
    drive(10'h111, 0, 0, 0, 0, 1, 0, 1, "R5 processor strobe with ce2 low");
    drive(10'h222, 0, 1, 1, 1, 0, 0, 1, "R5 controller strobe with ce3N high");
    drive(10'h333, 1, 1, 0, 1, 0, 0, 1, "R5 controller strobe with ce1N high");
    drive(10'h344, 1, 1, 0, 0, 1, 0, 1, "R5 processor strobe ignored when ce1N high");
    drive(10'h355, 1, 1, 0, 0, 1, 1, 1, "R5 ignored processor strobe then hold");

    // Mode change mid-burst from start 11 with all upper bits set
    drive(10'h3FF, 0, 1, 0, 0, 1, 1, 1, "R2 load all-ones address");
    advance(1, "R10 interleave step");
    advance(0, "R10 switch to linear");
    advance(1, "R10 switch back to interleave");
    advance(1, "R11 wrap with all upper bits set");

    // Start 00, linear
    drive(10'h100, 0, 1, 0, 1, 0, 1, 0, "R3 load start 00");
    advance(0, "R7 linear from 00");

    // Reset in mid-burst
    doReset("R1 reset mid-burst");

    @(negedge clk);
    @(negedge clk);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule